// File: doc/BRIEF.md
# Sequential 16-by-8 Divider With Overflow Quirk

This block divides a 16-bit dividend, given as a high byte and a low byte, by an 8-bit divisor over a fixed span of clock cycles. It returns an 8-bit quotient, an 8-bit remainder and four flags: half, overflow, negative and zero. The quotient can be too large for 8 bits. The block does not saturate or trap in that case. It follows a fixed alternate formula, so the same operands always give the same bytes. A zero divisor falls into that alternate path, so it never hangs and never yields an undefined value.

An operation is offered on `req_valid` together with the three operand bytes. The request is taken on a rising edge where both `req_valid` and `req_ready` are high. `req_ready` is the inverse of `busy`. While an operation is in flight, `req_valid` is ignored and no request is queued. The result side has no back-pressure. `res_valid` is a one-cycle pulse, and the result fields keep their value until the next pulse. Because `busy` drops in the pulse cycle, the next request can be taken at the same edge that follows the pulse. Internally the quotient comes from a restoring shift-subtract loop that produces one bit per cycle, followed by padding cycles.

Top module: `quirk_div16x8`

## Requirements
- R1: A request is accepted on a rising edge with `req_valid`=1 and `req_ready`=1. `busy` is then high, and `req_ready` low, for exactly 12 cycles after the accepting edge.
- R2: `res_valid` is high for exactly one cycle. It rises at the 12th rising edge after the accepting edge, and `busy` is low in that cycle.
- R3: When hi < 2·div (normal path), the quotient is (hi·256+lo)/div truncated to 8 bits, and the remainder is (hi·256+lo) mod div.
- R4: When hi ≥ 2·div (wrap path), let T = hi·256+lo−512·div and D = 256−div. The quotient is (255 − T/D) mod 256 and the remainder is (div + T mod D) mod 256.
- R5: A zero divisor always takes the wrap path with D = 256. The quotient is then 255−hi and the remainder is lo.
- R6: `res_h` is 1 exactly when hi[3:0] ≥ div[3:0].
- R7: `res_v` is 1 exactly when hi ≥ div.
- R8: `res_n` equals bit 7 of the quotient. `res_z` is 1 exactly when the quotient is 0.
- R9: A `req_valid` that arrives while `busy` is high is ignored. It neither changes the running operation nor produces an extra result.
- R10: All result fields hold their value between `res_valid` pulses.
- R11: While `rst_n` is low (asynchronous), `busy` and `res_valid` are 0 and all result fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Operands offered |
| req_ready | output | 1 | Request can be taken (not busy) |
| req_hi | input | 8 | Dividend high byte |
| req_lo | input | 8 | Dividend low byte |
| req_div | input | 8 | Divisor |
| busy | output | 1 | Operation in flight |
| res_valid | output | 1 | One-cycle result pulse |
| res_quot | output | 8 | Quotient |
| res_rem | output | 8 | Remainder |
| res_n | output | 1 | Negative flag |
| res_v | output | 1 | Overflow flag (hi ≥ div) |
| res_h | output | 1 | Half flag (nibble compare) |
| res_z | output | 1 | Zero flag |

## Verification
Every result field and flag is due in the cycle whose sampling point follows the 12th rising edge after the accepting edge. `busy` must stay high at each of the 12 sampling points before that cycle. The bench samples on falling edges and counts them from the accepting edge. It requires `res_valid` at count 12 and rejects a pulse at any earlier count. It then reads the fields at that same count, checks that the pulse is gone one count later, and checks that the fields are unchanged a few counts after that.

// File: rtl/qd_pkg.sv
package qd_pkg;
  typedef enum logic {
    PATH_NORMAL = 1'b0,
    PATH_WRAP   = 1'b1
  } qd_path_e;

  typedef struct packed {
    logic n;
    logic v;
    logic h;
    logic z;
  } qd_flags_t;
endpackage

// File: rtl/qd_classify.sv
module qd_classify #(
  parameter int W = 8
) (
  input  logic [W-1:0]      hi,
  input  logic [W-1:0]      dv,
  output logic              half_ge,
  output logic              full_ge,
  output qd_pkg::qd_path_e  path
);
  localparam int NIB = W / 2;

  always_comb begin
    half_ge = (hi[NIB-1:0] >= dv[NIB-1:0]);
    full_ge = (hi >= dv);
    path    = ({1'b0, hi} >= {dv, 1'b0}) ? qd_pkg::PATH_WRAP : qd_pkg::PATH_NORMAL;
  end
endmodule

// File: rtl/qd_prep.sv
module qd_prep #(
  parameter int W = 8
) (
  input  logic [W-1:0]      hi,
  input  logic [W-1:0]      lo,
  input  logic [W-1:0]      dv,
  input  qd_pkg::qd_path_e  path,
  output logic [2*W-1:0]    num,
  output logic [W:0]        den
);
  logic [2*W-1:0] raw;
  logic [2*W-1:0] shifted_dv;

  always_comb begin
    raw        = {hi, lo};
    shifted_dv = {dv[W-2:0], {(W+1){1'b0}}};
    if (path == qd_pkg::PATH_WRAP) begin
      num = raw - shifted_dv;
      den = {1'b1, {W{1'b0}}} - {1'b0, dv};
    end else begin
      num = raw;
      den = {1'b0, dv};
    end
  end
endmodule

// File: rtl/qd_core.sv
module qd_core #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [2*W-1:0] num,
  input  logic [W:0]     den,
  output logic [W-1:0]   quot,
  output logic [W-1:0]   rem
);
  logic [W:0] part;
  logic [W:0] shq;
  logic [W:0] dreg;
  logic       live;
  logic       below;
  logic [W:0] cat;
  logic [W:0] diff;

  always_comb begin
    below = ({part, shq[W]} < {1'b0, dreg});
    cat   = {part[W-1:0], shq[W]};
    diff  = cat - dreg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part <= '0;
      shq  <= '0;
      dreg <= '0;
      live <= 1'b0;
    end else if (load) begin
      part <= {2'b00, num[2*W-1:W+1]};
      shq  <= num[W:0];
      dreg <= den;
      live <= 1'b1;
    end else if (step) begin
      part <= below ? cat : diff;
      shq  <= {shq[W-1:0], ~below};
    end
  end

  assign quot = shq[W-1:0];
  assign rem  = part[W-1:0];

  // R3 / R4: restoring invariant, partial remainder stays below the divisor
  a_r3_partial_below: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (part < dreg));
endmodule

// File: rtl/qd_seq.sv
module qd_seq #(
  parameter int LAT   = 12,
  parameter int STEPS = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic accept,
  output logic busy,
  output logic step,
  output logic finish
);
  localparam int CW = $clog2(LAT);
  localparam logic [CW-1:0] LAST  = CW'(LAT - 1);
  localparam logic [CW-1:0] NSTEP = CW'(STEPS);

  logic [CW-1:0] cnt;

  always_comb begin
    accept = req_valid && !busy;
    step   = busy && (cnt < NSTEP);
    finish = busy && (cnt == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      busy <= !finish;
      cnt  <= finish ? '0 : cnt + 1'b1;
    end
  end

  // R1: busy persists until the final count
  a_r1_busy_span: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != LAST) |=> busy);
  // R1: an accepted request starts an operation
  a_r1_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && cnt == '0));
  // R9: no acceptance while busy
  a_r9_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept);
endmodule

// File: rtl/quirk_div16x8.sv
module quirk_div16x8 #(
  parameter int W       = 8,
  parameter int LATENCY = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [W-1:0] req_hi,
  input  logic [W-1:0] req_lo,
  input  logic [W-1:0] req_div,
  output logic         busy,
  output logic         res_valid,
  output logic [W-1:0] res_quot,
  output logic [W-1:0] res_rem,
  output logic         res_n,
  output logic         res_v,
  output logic         res_h,
  output logic         res_z
);
  import qd_pkg::*;

  localparam int STEPS = W + 1;

  logic            accept, step, finish;
  logic            half_ge, full_ge;
  qd_path_e        path_in, path_q;
  logic [2*W-1:0]  num;
  logic [W:0]      den;
  logic [W-1:0]    quot, rem;
  logic [W-1:0]    div_q;
  logic            h_q, v_q;
  logic [W-1:0]    fin_quot, fin_rem;
  qd_flags_t       flags;

  qd_seq #(.LAT(LATENCY), .STEPS(STEPS)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .accept(accept), .busy(busy), .step(step), .finish(finish)
  );

  qd_classify #(.W(W)) u_cls (
    .hi(req_hi), .dv(req_div),
    .half_ge(half_ge), .full_ge(full_ge), .path(path_in)
  );

  qd_prep #(.W(W)) u_prep (
    .hi(req_hi), .lo(req_lo), .dv(req_div), .path(path_in),
    .num(num), .den(den)
  );

  qd_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .load(accept), .step(step),
    .num(num), .den(den), .quot(quot), .rem(rem)
  );

  assign req_ready = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      path_q <= PATH_NORMAL;
      div_q  <= '0;
      h_q    <= 1'b0;
      v_q    <= 1'b0;
    end else if (accept) begin
      path_q <= path_in;
      div_q  <= req_div;
      h_q    <= half_ge;
      v_q    <= full_ge;
    end
  end

  always_comb begin
    if (path_q == PATH_WRAP) begin
      fin_quot = ~quot;
      fin_rem  = div_q + rem;
    end else begin
      fin_quot = quot;
      fin_rem  = rem;
    end
    flags.n = fin_quot[W-1];
    flags.v = v_q;
    flags.h = h_q;
    flags.z = (fin_quot == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_quot  <= '0;
      res_rem   <= '0;
      res_n     <= 1'b0;
      res_v     <= 1'b0;
      res_h     <= 1'b0;
      res_z     <= 1'b0;
    end else begin
      res_valid <= finish;
      if (finish) begin
        res_quot <= fin_quot;
        res_rem  <= fin_rem;
        res_n    <= flags.n;
        res_v    <= flags.v;
        res_h    <= flags.h;
        res_z    <= flags.z;
      end
    end
  end

  // R2: single-cycle pulse, only at the end of a busy span
  a_r2_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid || $past(req_valid));
  a_r2_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($past(busy) && !busy));
  // R10: results hold between pulses
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(res_quot) && $stable(res_rem) && $stable(res_z)));
  // R8: zero flag agrees with the delivered quotient
  a_r8_zero: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_z == (res_quot == '0)));
endmodule

// File: tb/quirk_div16x8_test.sv
`timescale 1ns/1ps
module quirk_div16x8_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [7:0] req_hi = '0, req_lo = '0, req_div = '0;
  logic       busy, res_valid, res_n, res_v, res_h, res_z;
  logic [7:0] res_quot, res_rem;

  int n_run = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  quirk_div16x8 uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_hi(req_hi), .req_lo(req_lo), .req_div(req_div), .busy(busy),
    .res_valid(res_valid), .res_quot(res_quot), .res_rem(res_rem),
    .res_n(res_n), .res_v(res_v), .res_h(res_h), .res_z(res_z)
  );

  // {hi, lo, div, quot, rem, h, v}
  localparam logic [55:0] VECS [0:8] = '{
    56'h00_64_07_0E_02_00_00,
    56'h12_34_20_91_14_01_00,
    56'h01_00_01_00_00_01_01,
    56'h34_56_00_CB_56_01_01,
    56'hFF_FF_FF_01_00_01_01,
    56'h10_00_04_F7_24_00_01,
    56'h80_FF_7F_04_03_00_01,
    56'hFF_FF_7F_FC_FB_01_01,
    56'h00_00_00_FF_00_01_01
  };

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [17:0] model(input int hi, input int lo, input int dv);
    int ya, t, d, q, r;
    logic h, v;
    ya = hi * 256 + lo;
    h  = (hi % 16) >= (dv % 16);
    v  = hi >= dv;
    if (hi < 2 * dv) begin
      q = ya / dv;
      r = ya % dv;
    end else begin
      t = ya - 512 * dv;
      d = 256 - dv;
      q = 255 - t / d;
      r = dv + t % d;
    end
    return {8'(q), 8'(r), h, v};
  endfunction

  // issue one request; optionally inject a second request while busy
  task automatic run_op(input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] dv,
                        input logic [17:0] exp, input logic inject, input string tag);
    int cyc;
    logic [7:0] q0;
    @(negedge clk);
    req_hi = hi; req_lo = lo; req_div = dv; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (!res_valid && cyc < 40) begin
      // R1: busy and not ready during the operation
      check(busy && !req_ready, {tag, " R1 busy"}, busy, 1);
      if (inject && cyc == 5) begin
        req_hi = ~hi; req_lo = ~lo; req_div = dv + 8'd3; req_valid = 1'b1;
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    req_valid = 1'b0;
    check(cyc == 12, {tag, " R2 latency"}, cyc, 12);
    check(!busy, {tag, " R2 busy low at done"}, busy, 0);
    check(res_quot == exp[17:10], {tag, " R3/R4 quotient"}, res_quot, exp[17:10]);
    check(res_rem == exp[9:2], {tag, " R3/R4 remainder"}, res_rem, exp[9:2]);
    check(res_h == exp[1], {tag, " R6 half"}, res_h, exp[1]);
    check(res_v == exp[0], {tag, " R7 overflow"}, res_v, exp[0]);
    check(res_n == exp[17] && res_z == (exp[17:10] == 0), {tag, " R8 n/z"},
          {res_n, res_z}, {exp[17], exp[17:10] == 0});
    q0 = res_quot;
    @(negedge clk);
    check(!res_valid, {tag, " R2 single pulse / R9 no extra"}, res_valid, 0);
    repeat (3) @(negedge clk);
    check(res_quot == q0 && !res_valid, {tag, " R10 hold"}, res_quot, q0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check(!busy && !res_valid && res_quot == 0 && res_rem == 0, "R11 reset", busy, 0);
        check(req_ready, "R1 ready at reset", req_ready, 1);
        rst_n = 1'b1;

        foreach (VECS[i]) begin
          logic [55:0] e;
          e = VECS[i];
          run_op(e[55:48], e[47:40], e[39:32],
                 {e[31:24], e[23:16], e[8], e[0]}, 1'b0, "table");
        end

        // R5: zero divisor cases
        run_op(8'h9A, 8'h3C, 8'h00, {8'h65, 8'h3C, 1'b1, 1'b1}, 1'b0, "R5 zero div");
        run_op(8'hFF, 8'h01, 8'h00, {8'h00, 8'h01, 1'b1, 1'b1}, 1'b0, "R5 zero div z");

        // R9: request while busy ignored
        run_op(8'h12, 8'h34, 8'h20, model(8'h12, 8'h34, 8'h20), 1'b1, "R9 inject");

        // sweep against the model, both paths
        for (int k = 0; k < 40; k++) begin
          int hi, lo, dv;
          hi = (k * 37 + 5) % 256;
          lo = (k * 91 + 17) % 256;
          dv = (k * 53 + 3) % 256;
          if (k % 5 == 0) dv = dv % 40;
          run_op(8'(hi), 8'(lo), 8'(dv), model(hi, lo, dv), 1'b0, "sweep R3 R4");
        end

        // R11: reset during an operation
        @(negedge clk);
        req_hi = 8'h05; req_lo = 8'h00; req_div = 8'h09; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!busy && !res_valid && res_quot == 0 && res_rem == 0 && !res_h,
              "R11 reset mid-op", busy, 0);
        rst_n = 1'b1;
        repeat (14) @(negedge clk);
        check(!res_valid && !busy, "R11 no stale result", res_valid, 0);
      end
      begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule